// File: doc/BRIEF.md
# Indexed Configuration Memory Port Unit

This block gives a host two byte-wide access points into a small configuration memory that keeps its contents across a reset. The host first writes a select byte through the index strobe. The low six bits of that byte choose a location, and the top bit is held on a separate NMI-mask output. The host then reads or writes the chosen byte through the data strobes. A data read returns the selected byte one cycle later and then moves the selection to the fixed status location 0x0D. Software that does a read-modify-write must therefore write the index again before it writes the new value back.

The memory has 64 byte locations. Offsets 0x0A, 0x0B and 0x0C are not plain storage. They are the control and status registers of a separate periodic-timer block. Writes to them are forwarded to that block, and reads return its register values. A read of 0x0C also sends a one-cycle strobe so that the timer can clear its pending flags. Offset 0x0D is a read-only status byte.

A small state machine sequences each access. Its states are:
- `S_IDLE`: no response is pending.
- `S_RD_PLAIN`: presents a captured storage or status-byte read.
- `S_RD_TMR`: presents a captured timer-register read.
- `S_WR_TMR`: presents a forwarded timer write.

Every state is left after one cycle. On each clock edge the next state is chosen from the strobes seen in the cycle before the edge:
- `S_IDLE` is entered when no data operation was taken, or the data operation was an index write, a plain storage write, or an ignored write to 0x0D.
- `S_RD_PLAIN` is entered on a data read of any offset outside 0x0A to 0x0C.
- `S_RD_TMR` is entered on a data read of 0x0A to 0x0C.
- `S_WR_TMR` is entered on a data write to 0x0A to 0x0C.

Top module: `cmos_port_unit`

## Requirements
- R1: After reset, `nmi_mask` is 0, the index selects 0x0D, and `rd_valid`, `tmr_wr` and `tmr_c_rd_stb` are 0.
- R2: An index write selects the offset given by `wdata[5:0]` and ignores `wdata[6]`. It loads `wdata[7]` into `nmi_mask`, which then holds its value until the next index write. Data reads and writes leave `nmi_mask` unchanged.
- R3: A data write to any offset other than 0x0A to 0x0D stores `wdata` at that offset. A data write does not change the index.
- R4: A data read sets `rd_valid` high for exactly one cycle, in the cycle after the strobe, with the selected byte on `rdata`. After the read the index is 0x0D.
- R5: Offset 0x0D always reads 0x80, and writes to it are ignored.
- R6: A data write to 0x0A, 0x0B or 0x0C is not stored locally. In the next cycle `tmr_wr` is high for one cycle, with `tmr_wsel` set to 0, 1 or 2 respectively and `tmr_wdata` equal to the written byte.
- R7: A data read of 0x0A, 0x0B or 0x0C returns the value on `tmr_a`, `tmr_b` or `tmr_c` as seen in the strobe cycle.
- R8: A data read of 0x0C raises `tmr_c_rd_stb` for exactly one cycle, together with `rd_valid`. A read of any other offset leaves it low.
- R9: When strobes coincide, the index write wins over the data read, and the data read wins over the data write. A strobe that loses has no effect.
- R10: Reset does not clear the stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_wr | input | 1 | Index write strobe |
| dat_wr | input | 1 | Data write strobe |
| dat_rd | input | 1 | Data read strobe |
| wdata | input | 8 | Byte written through either strobe |
| rdata | output | 8 | Read result |
| rd_valid | output | 1 | `rdata` valid (one cycle after the read strobe) |
| nmi_mask | output | 1 | Held top bit of the last index write |
| tmr_a | input | 8 | Timer register at 0x0A |
| tmr_b | input | 8 | Timer register at 0x0B |
| tmr_c | input | 8 | Timer register at 0x0C |
| tmr_wr | output | 1 | Forwarded timer write pulse |
| tmr_wsel | output | 2 | Target of the forwarded write (0=0x0A, 1=0x0B, 2=0x0C) |
| tmr_wdata | output | 8 | Forwarded write byte |
| tmr_c_rd_stb | output | 1 | One-cycle pulse after a read of 0x0C |

## Verification
On every cycle, the assertions check these properties:
- the NMI mask holds its value between index writes;
- each accepted read produces a response pulse;
- a read of 0x0D returns 0x80;
- a write to the timer range produces a forwarded pulse;
- the clear strobe coincides with a read response and never lasts two cycles.

Other behaviours show only in the bench's scenarios: the full sweep of all 60 storage locations with varied select bytes, the index falling back to 0x0D after a read, the priority between coinciding strobes, and storage surviving a reset.

// File: rtl/cmos_pkg.sv
package cmos_pkg;
    localparam int OFF_TMR_A  = 10;
    localparam int OFF_TMR_C  = 12;
    localparam int OFF_STATUS = 13;
    localparam int STATUS_VAL = 8'h80;

    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_RD_PLAIN = 2'd1,
        S_RD_TMR   = 2'd2,
        S_WR_TMR   = 2'd3
    } port_state_e;
endpackage

// File: rtl/cmos_index_reg.sv
module cmos_index_reg #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int RST_IDX = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_idx,
    input  logic [DATA_W-1:0] set_val,
    input  logic              force_d,
    output logic [ADDR_W-1:0] idx_o,
    output logic              nmi_o
);
    localparam logic [ADDR_W-1:0] IDX_RST = ADDR_W'(RST_IDX);

    logic [ADDR_W-1:0] idx_q;
    logic              nmi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= IDX_RST;
            nmi_q <= 1'b0;
        end else if (set_idx) begin
            idx_q <= set_val[ADDR_W-1:0];
            nmi_q <= set_val[DATA_W-1];
        end else if (force_d) begin
            idx_q <= IDX_RST;
        end
    end

    assign idx_o = idx_q;
    assign nmi_o = nmi_q;

    // R2: mask only moves on an index write
    a_r2_nmi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !set_idx |=> $stable(nmi_q));
endmodule

// File: rtl/cmos_ram.sv
module cmos_ram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // R10: no reset on the storage array
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/cmos_port_fsm.sv
module cmos_port_fsm
    import cmos_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic              dat_wr,
    input  logic              dat_rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] cur_idx,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic [DATA_W-1:0] tmr_a,
    input  logic [DATA_W-1:0] tmr_b,
    input  logic [DATA_W-1:0] tmr_c,
    output logic              set_idx,
    output logic              force_d,
    output logic              ram_we,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_valid,
    output logic              tmr_wr,
    output logic [1:0]        tmr_wsel,
    output logic [DATA_W-1:0] tmr_wdata,
    output logic              tmr_c_rd_stb
);
    localparam logic [ADDR_W-1:0] IDX_A  = ADDR_W'(OFF_TMR_A);
    localparam logic [ADDR_W-1:0] IDX_C  = ADDR_W'(OFF_TMR_C);
    localparam logic [ADDR_W-1:0] IDX_D  = ADDR_W'(OFF_STATUS);
    localparam logic [DATA_W-1:0] D_BYTE = DATA_W'(STATUS_VAL);
    localparam logic [1:0]        SEL_C  = 2'(OFF_TMR_C - OFF_TMR_A);

    port_state_e       state_q, state_d;
    logic [DATA_W-1:0] rdata_q, rdata_d;
    logic [DATA_W-1:0] wdata_q;
    logic [1:0]        sel_q, sel_d;
    logic              in_tmr, is_d;
    logic [1:0]        tmr_off;
    logic [DATA_W-1:0] tmr_byte;

    always_comb begin
        in_tmr  = (cur_idx >= IDX_A) && (cur_idx <= IDX_C);
        is_d    = (cur_idx == IDX_D);
        tmr_off = 2'(cur_idx - IDX_A);
        unique case (tmr_off)
            2'd0:    tmr_byte = tmr_a;
            2'd1:    tmr_byte = tmr_b;
            default: tmr_byte = tmr_c;
        endcase
    end

    // next-state and capture decode; R9 priority: index > read > write
    always_comb begin
        state_d = S_IDLE;
        rdata_d = rdata_q;
        sel_d   = sel_q;
        set_idx = 1'b0;
        force_d = 1'b0;
        ram_we  = 1'b0;
        if (idx_wr) begin
            set_idx = 1'b1;
        end else if (dat_rd) begin
            force_d = 1'b1;
            if (in_tmr) begin
                state_d = S_RD_TMR;
                rdata_d = tmr_byte;
                sel_d   = tmr_off;
            end else begin
                state_d = S_RD_PLAIN;
                rdata_d = is_d ? D_BYTE : ram_rdata;
            end
        end else if (dat_wr) begin
            if (in_tmr) begin
                state_d = S_WR_TMR;
                sel_d   = tmr_off;
            end else if (!is_d) begin
                ram_we = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            sel_q   <= '0;
            wdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
            sel_q   <= sel_d;
            if (dat_wr) wdata_q <= wdata;
        end
    end

    always_comb begin
        rd_valid     = 1'b0;
        tmr_wr       = 1'b0;
        tmr_c_rd_stb = 1'b0;
        unique case (state_q)
            S_IDLE:     ;
            S_RD_PLAIN: rd_valid = 1'b1;
            S_RD_TMR: begin
                rd_valid     = 1'b1;
                tmr_c_rd_stb = (sel_q == SEL_C);
            end
            S_WR_TMR:   tmr_wr = 1'b1;
            default:    ;
        endcase
    end

    assign rdata     = rdata_q;
    assign tmr_wsel  = sel_q;
    assign tmr_wdata = wdata_q;

    a_r4_read_responds: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_rd && !idx_wr) |=> rd_valid);
    a_r5_status_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_rd && !idx_wr && cur_idx == IDX_D) |=> (rdata == D_BYTE));
    a_r6_fwd_write: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !dat_rd && !idx_wr && in_tmr) |=> (tmr_wr && !rd_valid));
    a_r8_stb_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_c_rd_stb |-> rd_valid);
    a_r8_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_c_rd_stb |=> !tmr_c_rd_stb);
endmodule

// File: rtl/cmos_port_unit.sv
module cmos_port_unit
    import cmos_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic              dat_wr,
    input  logic              dat_rd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_valid,
    output logic              nmi_mask,
    input  logic [DATA_W-1:0] tmr_a,
    input  logic [DATA_W-1:0] tmr_b,
    input  logic [DATA_W-1:0] tmr_c,
    output logic              tmr_wr,
    output logic [1:0]        tmr_wsel,
    output logic [DATA_W-1:0] tmr_wdata,
    output logic              tmr_c_rd_stb
);
    logic [ADDR_W-1:0] cur_idx;
    logic [DATA_W-1:0] ram_rdata;
    logic              set_idx, force_d, ram_we;

    cmos_index_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_IDX(OFF_STATUS)) u_idx (
        .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .set_val(wdata),
        .force_d(force_d), .idx_o(cur_idx), .nmi_o(nmi_mask)
    );

    cmos_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk(clk), .we(ram_we), .addr(cur_idx), .wdata(wdata), .rdata(ram_rdata)
    );

    cmos_port_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .dat_wr(dat_wr), .dat_rd(dat_rd),
        .wdata(wdata), .cur_idx(cur_idx), .ram_rdata(ram_rdata),
        .tmr_a(tmr_a), .tmr_b(tmr_b), .tmr_c(tmr_c),
        .set_idx(set_idx), .force_d(force_d), .ram_we(ram_we),
        .rdata(rdata), .rd_valid(rd_valid), .tmr_wr(tmr_wr), .tmr_wsel(tmr_wsel),
        .tmr_wdata(tmr_wdata), .tmr_c_rd_stb(tmr_c_rd_stb)
    );
endmodule

// File: tb/cmos_port_unit_tb.sv
`timescale 1ns/1ps
module cmos_port_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idx_wr = 1'b0, dat_wr = 1'b0, dat_rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rd_valid, nmi_mask;
    logic [7:0] ta = 8'h26, tb_ = 8'h02, tc = 8'h00;
    logic       tmr_wr, tmr_c_rd_stb;
    logic [1:0] tmr_wsel;
    logic [7:0] tmr_wdata;
    int total = 0, bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cmos_port_unit u_dut (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .dat_wr(dat_wr), .dat_rd(dat_rd),
        .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .nmi_mask(nmi_mask),
        .tmr_a(ta), .tmr_b(tb_), .tmr_c(tc), .tmr_wr(tmr_wr), .tmr_wsel(tmr_wsel),
        .tmr_wdata(tmr_wdata), .tmr_c_rd_stb(tmr_c_rd_stb)
    );

    // timer-side model
    always @(posedge clk) begin
        if (tmr_wr) begin
            case (tmr_wsel)
                2'd0: ta <= tmr_wdata;
                2'd1: tb_ <= tmr_wdata;
                default: tc <= tmr_wdata;
            endcase
        end
        if (tmr_c_rd_stb) tc <= 8'h00;
    end

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37 + 11) ^ 8'h5A);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic strobe(input bit iw, input bit dw, input bit dr, input logic [7:0] v);
        idx_wr = iw; dat_wr = dw; dat_rd = dr; wdata = v;
        @(negedge clk);
        idx_wr = 0; dat_wr = 0; dat_rd = 0;
    endtask

    task automatic idx_w(input logic [7:0] v); strobe(1, 0, 0, v); endtask
    task automatic dat_w(input logic [7:0] v); strobe(0, 1, 0, v); endtask
    task automatic dat_r(output logic [7:0] d, output logic v, output logic s);
        strobe(0, 0, 1, 8'h00);
        d = rdata; v = rd_valid; s = tmr_c_rd_stb;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d; logic v, s;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(nmi_mask == 0 && rd_valid == 0 && tmr_wr == 0 && tmr_c_rd_stb == 0, "R1",
            {nmi_mask, rd_valid, tmr_wr, tmr_c_rd_stb}, 0);
        dat_r(d, v, s);
        chk(v && d == 8'h80, "R1 index at 0x0D", d, 8'h80);

        // R3/R2 sweep: write every storage offset, varied bit6/bit7
        for (int i = 0; i < 64; i++) begin
            if (i >= 10 && i <= 13) continue;
            idx_w(8'(i) | ((i % 2) ? 8'h40 : 8'h00) | ((i % 3 == 0) ? 8'h80 : 8'h00));
            chk(nmi_mask == (i % 3 == 0), "R2 nmi", nmi_mask, (i % 3 == 0));
            dat_w(pat(i));
        end
        for (int i = 0; i < 64; i++) begin
            if (i >= 10 && i <= 13) continue;
            idx_w(8'(i) | ((i % 2) ? 8'h00 : 8'h40));
            dat_r(d, v, s);
            chk(v && d == pat(i), "R3 readback", d, pat(i));
            chk(!s, "R8 no strobe", s, 0);
            @(negedge clk);
            chk(!rd_valid, "R4 single pulse", rd_valid, 0);
            if (i % 8 == 0) begin
                dat_r(d, v, s);
                chk(v && d == 8'h80, "R4 index to 0x0D", d, 8'h80);
            end
        end

        // R3 write leaves index in place
        idx_w(8'h05); dat_w(8'h11); dat_w(8'h22);
        dat_r(d, v, s);
        chk(d == 8'h22, "R3 index kept", d, 8'h22);

        // R2 nmi unaffected by data ops
        idx_w(8'h85);
        dat_w(pat(5));
        dat_r(d, v, s);
        chk(nmi_mask == 1 && d == pat(5), "R2 nmi hold", nmi_mask, 1);
        idx_w(8'h05);
        chk(nmi_mask == 0, "R2 nmi clear", nmi_mask, 0);

        // R5 status byte ignores writes
        idx_w(8'h0D); dat_w(8'h00);
        dat_r(d, v, s);
        chk(d == 8'h80, "R5", d, 8'h80);

        // R6 forwarded writes
        for (int k = 0; k < 3; k++) begin
            idx_w(8'(10 + k));
            dat_w(8'h40 + 8'(k));
            chk(tmr_wr && tmr_wsel == 2'(k) && tmr_wdata == 8'h40 + 8'(k), "R6",
                {tmr_wr, tmr_wsel, tmr_wdata}, {1'b1, 2'(k), 8'h40 + 8'(k)});
            @(negedge clk);
            chk(!tmr_wr, "R6 single pulse", tmr_wr, 0);
        end

        // R7 timer reads
        idx_w(8'h0A); dat_r(d, v, s);
        chk(v && d == 8'h40 && !s, "R7 A", d, 8'h40);
        idx_w(8'h0B); dat_r(d, v, s);
        chk(v && d == 8'h41 && !s, "R7 B", d, 8'h41);

        // R8 clear strobe on C read
        idx_w(8'h0C); dat_r(d, v, s);
        chk(v && d == 8'h42, "R7 C", d, 8'h42);
        chk(s, "R8 strobe", s, 1);
        @(negedge clk);
        chk(!tmr_c_rd_stb, "R8 one cycle", tmr_c_rd_stb, 0);
        idx_w(8'h0C); dat_r(d, v, s);
        chk(d == 8'h00, "R8 cleared", d, 8'h00);

        // R9 priority
        idx_w(8'h05);
        strobe(1, 0, 1, 8'h07);
        chk(!rd_valid, "R9 index beats read", rd_valid, 0);
        dat_r(d, v, s);
        chk(d == pat(7), "R9 index applied", d, pat(7));
        idx_w(8'h06);
        strobe(0, 1, 1, 8'hEE);
        chk(rd_valid && rdata == pat(6), "R9 read beats write", rdata, pat(6));
        idx_w(8'h06); dat_r(d, v, s);
        chk(d == pat(6), "R9 write dropped", d, pat(6));
        idx_w(8'h09);
        strobe(1, 1, 0, 8'h08);
        dat_r(d, v, s);
        chk(d == pat(8), "R9 index beats write", d, pat(8));

        // R10 storage survives reset
        idx_w(8'h94);
        rst_n = 1'b0; @(negedge clk); @(negedge clk); rst_n = 1'b1;
        chk(nmi_mask == 0, "R1 nmi after reset", nmi_mask, 0);
        dat_r(d, v, s);
        chk(d == 8'h80, "R1 index after reset", d, 8'h80);
        idx_w(8'h14); dat_r(d, v, s);
        chk(d == pat(20), "R10", d, pat(20));

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule